// File: doc/BRIEF.md
# Interrupt Context Save and Restore Sequencer

This block belongs to the core of an 8-bit processor. When the core decides to take an interrupt, it raises a one-cycle take strobe with the chosen vector address and presents the live program counter, accumulator, low index byte, condition codes and stack pointer. The block then writes a five-byte context frame onto a stack that grows toward lower addresses. It sets the interrupt mask in the saved copy of the condition codes and fetches the two-byte handler address into the program counter.

On a return strobe the block reads the frame back in reverse order, from the current stack pointer upward. It restores the condition codes, accumulator, index low byte and program counter. It then issues three sequential program reads from the restored program counter to refill the instruction prefetch. The high index byte is never part of the frame, so the core keeps it untouched across both sequences. All traffic uses one byte-wide memory port with one access per clock and a combinational read path.

Top module: `irq_ctx_seq`

## Requirements
- R1: While reset is low, and on the first cycle after release, busy_o, done_o, mem_we_o and mem_re_o are 0 and sp_o and pc_o are 0.
- R2: A take writes exactly five bytes, one per cycle, at addresses sp_i, sp_i-1, sp_i-2, sp_i-3, sp_i-4. The data in that order is PC[7:0], PC[15:8], X, A and the unmodified CCR. Read and write strobes are never high together.
- R3: After a take, sp_o equals sp_i minus 5 modulo 65536. Every write leaves the stack pointer one below the address just written.
- R4: After a take, ccr_o equals ccr_i with bit 3 (interrupt mask) set, x_o and a_o equal the captured inputs, and pc_o is the byte at the vector address (upper half) joined with the byte at the vector address plus 1 (lower half).
- R5: A return reads sp_i+1 through sp_i+5 modulo 65536. The bytes go in that order into CCR, A, X, PC[15:8] and PC[7:0], and sp_o ends at sp_i+5. Each read comes after the stack pointer is raised by one.
- R6: After the frame is read, three reads go to the restored PC, PC+1 and PC+2. pf_o then holds those bytes with the byte at PC in bits [7:0].
- R7: busy_o stays high for 7 cycles on a take and 8 cycles on a return. done_o is a one-cycle pulse in the first cycle with busy_o low.
- R8: Take and return strobes are ignored while busy_o is high. If both rise together while idle, the take is served.
- R9: Nested takes, each using the stack pointer left by the previous one, stack frames back to back. Returns then unwind them in last-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| take_i | input | 1 | Interrupt take strobe |
| vec_i | input | 16 | Address of the chosen vector |
| rti_i | input | 1 | Return-from-interrupt strobe |
| pc_i | input | 16 | Program counter to save (next instruction) |
| x_i | input | 8 | Low index byte to save |
| a_i | input | 8 | Accumulator to save |
| ccr_i | input | 8 | Condition codes to save |
| sp_i | input | 16 | Stack pointer at strobe time |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read enable |
| mem_rdata_i | input | 8 | Memory read data, valid in the same cycle |
| pc_o | output | 16 | Resulting program counter |
| x_o | output | 8 | Resulting low index byte |
| a_o | output | 8 | Resulting accumulator |
| ccr_o | output | 8 | Resulting condition codes |
| sp_o | output | 16 | Resulting stack pointer |
| pf_o | output | 24 | Refilled prefetch bytes |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed pulse |

## Verification
The hardest situations to reach are a stack pointer that crosses address zero in the middle of a frame and a strobe that arrives while a sequence is already running. The stimulus table therefore places one frame so that its writes wrap from 0x0000 to 0xFFFF. The directed tests raise both strobes with conflicting inputs in the middle of a take, then check that the frame and cycle count still match the first request. Nested takes followed by two returns check that the frames unwind in stack order.

// File: rtl/irq_frame_pkg.sv
// Package: shared constants and phase/slot encodings for the interrupt
// context sequencer. Assumes an 8-bit data path and a 16-bit address space.
package irq_frame_pkg;
    localparam int unsigned FRAME_LEN = 5;  // bytes saved per interrupt
    localparam int unsigned VEC_LEN   = 2;  // bytes in a handler vector
    localparam int unsigned FILL_LEN  = 3;  // prefetch refill reads
    localparam int unsigned STEP_W    = 3;  // wide enough for the longest phase
    localparam int unsigned MASK_BIT  = 3;  // interrupt mask position in CCR

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PUSH,
        PH_VEC,
        PH_POP,
        PH_FILL
    } phase_e;

    // Frame slots in push order; pops walk this list backwards.
    typedef enum logic [2:0] {
        SLOT_PCL = 3'd0,
        SLOT_PCH = 3'd1,
        SLOT_XL  = 3'd2,
        SLOT_ACC = 3'd3,
        SLOT_CCR = 3'd4
    } slot_e;
endpackage

// File: rtl/irq_seq_ctrl.sv
// Module: phase and step sequencer. Accepts a take or return strobe only when
// idle (take wins a tie), steps through push/vector or pop/fill phases one
// memory access per cycle, and pulses done when it returns to idle.
// Assumes strobes are single-cycle but tolerates longer ones.
module irq_seq_ctrl
    import irq_frame_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              rti_i,
    output phase_e            phase_o,
    output logic [STEP_W-1:0] step_o,
    output logic              start_take_o,
    output logic              start_rti_o,
    output logic              busy_o,
    output logic              done_o
);
    phase_e            phase_q;
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] last_step;
    logic              at_last;
    logic              done_q;

    // Strobe acceptance: only in idle, take has priority.
    always_comb begin
        start_take_o = (phase_q == PH_IDLE) && take_i;
        start_rti_o  = (phase_q == PH_IDLE) && rti_i && !take_i;
    end

    // Final step index of the current phase.
    always_comb begin
        case (phase_q)
            PH_PUSH: last_step = STEP_W'(FRAME_LEN - 1);
            PH_VEC:  last_step = STEP_W'(VEC_LEN - 1);
            PH_POP:  last_step = STEP_W'(FRAME_LEN - 1);
            PH_FILL: last_step = STEP_W'(FILL_LEN - 1);
            default: last_step = '0;
        endcase
        at_last = (step_q == last_step);
    end

    // Phase and step register with done pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            step_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (phase_q == PH_IDLE) begin
                step_q <= '0;
                if (start_take_o)     phase_q <= PH_PUSH;
                else if (start_rti_o) phase_q <= PH_POP;
            end else if (at_last) begin
                step_q <= '0;
                case (phase_q)
                    PH_PUSH: phase_q <= PH_VEC;
                    PH_POP:  phase_q <= PH_FILL;
                    default: begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end
                endcase
            end else begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    assign phase_o = phase_q;
    assign step_o  = step_q;
    assign busy_o  = (phase_q != PH_IDLE);
    assign done_o  = done_q;
endmodule

// File: rtl/irq_stack_addr.sv
// Module: stack pointer register and memory address selection. The stack
// pointer addresses the next free byte: pushes use it then decrement, pops
// increment then use it. Arithmetic wraps modulo 2**ADDR_W.
module irq_stack_addr
    import irq_frame_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic              start_take_i,
    input  logic              start_rti_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [ADDR_W-1:0] vec_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic [ADDR_W-1:0] sp_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] sp_q;
    logic [ADDR_W-1:0] vec_q;
    logic [ADDR_W-1:0] sp_up;
    logic [ADDR_W-1:0] step_ext;

    assign sp_up    = sp_q + 1'b1;
    assign step_ext = ADDR_W'(step_i);

    // Stack pointer load on acceptance, move once per frame access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q  <= '0;
            vec_q <= '0;
        end else begin
            if (start_take_i) vec_q <= vec_i;
            if (start_take_i || start_rti_i) sp_q <= sp_i;
            else if (phase_i == PH_PUSH)     sp_q <= sp_q - 1'b1;
            else if (phase_i == PH_POP)      sp_q <= sp_up;
        end
    end

    // Address for the access of the current cycle.
    always_comb begin
        case (phase_i)
            PH_PUSH: addr_o = sp_q;
            PH_POP:  addr_o = sp_up;
            PH_VEC:  addr_o = vec_q + step_ext;
            PH_FILL: addr_o = pc_i + step_ext;
            default: addr_o = sp_q;
        endcase
    end

    assign sp_o = sp_q;
endmodule

// File: rtl/irq_ctx_file.sv
// Module: context register file. Captures the live context on a take,
// supplies frame bytes in push order, sets the interrupt mask after the last
// push, loads the vector into PC, restores the frame on a return and collects
// prefetch refill bytes. Assumes ADDR_W is twice DATA_W (PC spans two bytes).
module irq_ctx_file
    import irq_frame_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  phase_e                     phase_i,
    input  logic [STEP_W-1:0]          step_i,
    input  logic                       start_take_i,
    input  logic [ADDR_W-1:0]          pc_i,
    input  logic [DATA_W-1:0]          x_i,
    input  logic [DATA_W-1:0]          a_i,
    input  logic [DATA_W-1:0]          ccr_i,
    input  logic [DATA_W-1:0]          rdata_i,
    output logic [ADDR_W-1:0]          pc_o,
    output logic [DATA_W-1:0]          x_o,
    output logic [DATA_W-1:0]          a_o,
    output logic [DATA_W-1:0]          ccr_o,
    output logic [FILL_LEN*DATA_W-1:0] pf_o,
    output logic [DATA_W-1:0]          wdata_o
);
    localparam int unsigned PC_HI = ADDR_W - 1;
    localparam int unsigned PC_LO = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] x_q;
    logic [DATA_W-1:0] a_q;
    logic [DATA_W-1:0] ccr_q;
    slot_e             push_slot;
    slot_e             pop_slot;

    assign push_slot = slot_e'(step_i);
    assign pop_slot  = slot_e'(STEP_W'(FRAME_LEN - 1) - step_i);

    // Frame byte for the current push.
    always_comb begin
        case (push_slot)
            SLOT_PCL: wdata_o = pc_q[DATA_W-1:0];
            SLOT_PCH: wdata_o = pc_q[PC_HI:PC_LO];
            SLOT_XL:  wdata_o = x_q;
            SLOT_ACC: wdata_o = a_q;
            default:  wdata_o = ccr_q;
        endcase
    end

    // Context registers: capture, mask set, vector load and restore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            x_q   <= '0;
            a_q   <= '0;
            ccr_q <= '0;
        end else if (start_take_i) begin
            pc_q  <= pc_i;
            x_q   <= x_i;
            a_q   <= a_i;
            ccr_q <= ccr_i;
        end else begin
            case (phase_i)
                PH_PUSH: if (push_slot == SLOT_CCR) ccr_q[MASK_BIT] <= 1'b1;
                PH_VEC: begin
                    if (step_i == '0) pc_q[PC_HI:PC_LO]  <= rdata_i;
                    else              pc_q[DATA_W-1:0]   <= rdata_i;
                end
                PH_POP: begin
                    case (pop_slot)
                        SLOT_CCR: ccr_q               <= rdata_i;
                        SLOT_ACC: a_q                 <= rdata_i;
                        SLOT_XL:  x_q                 <= rdata_i;
                        SLOT_PCH: pc_q[PC_HI:PC_LO]   <= rdata_i;
                        default:  pc_q[DATA_W-1:0]    <= rdata_i;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // One byte lane per refill read.
    for (genvar g = 0; g < FILL_LEN; g++) begin : g_fill
        logic [DATA_W-1:0] lane_q;
        // Capture the refill byte belonging to this lane.
        always_ff @(posedge clk) begin
            if (!rst_n) lane_q <= '0;
            else if (phase_i == PH_FILL && step_i == STEP_W'(g)) lane_q <= rdata_i;
        end
        assign pf_o[g*DATA_W +: DATA_W] = lane_q;
    end

    assign pc_o  = pc_q;
    assign x_o   = x_q;
    assign a_o   = a_q;
    assign ccr_o = ccr_q;
endmodule

// File: rtl/irq_ctx_seq.sv
// Module: top of the interrupt context sequencer. Ties the phase controller,
// stack/address unit and context register file to one byte-wide memory port.
// Assumes single-cycle memory with combinational read data.
module irq_ctx_seq
    import irq_frame_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned PF_W  = FILL_LEN * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [ADDR_W-1:0] vec_i,
    input  logic              rti_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] ccr_i,
    input  logic [ADDR_W-1:0] sp_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [DATA_W-1:0] x_o,
    output logic [DATA_W-1:0] a_o,
    output logic [DATA_W-1:0] ccr_o,
    output logic [ADDR_W-1:0] sp_o,
    output logic [PF_W-1:0]   pf_o,
    output logic              busy_o,
    output logic              done_o
);
    phase_e            phase;
    logic [STEP_W-1:0] step;
    logic              start_take;
    logic              start_rti;
    logic              is_pop;
    logic              is_fill;

    irq_seq_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .take_i       (take_i),
        .rti_i        (rti_i),
        .phase_o      (phase),
        .step_o       (step),
        .start_take_o (start_take),
        .start_rti_o  (start_rti),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    irq_stack_addr #(.ADDR_W(ADDR_W)) u_stack (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase_i      (phase),
        .step_i       (step),
        .start_take_i (start_take),
        .start_rti_i  (start_rti),
        .sp_i         (sp_i),
        .vec_i        (vec_i),
        .pc_i         (pc_o),
        .sp_o         (sp_o),
        .addr_o       (mem_addr_o)
    );

    irq_ctx_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctx (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase_i      (phase),
        .step_i       (step),
        .start_take_i (start_take),
        .pc_i         (pc_i),
        .x_i          (x_i),
        .a_i          (a_i),
        .ccr_i        (ccr_i),
        .rdata_i      (mem_rdata_i),
        .pc_o         (pc_o),
        .x_o          (x_o),
        .a_o          (a_o),
        .ccr_o        (ccr_o),
        .pf_o         (pf_o),
        .wdata_o      (mem_wdata_o)
    );

    // Memory strobes derived from the active phase.
    always_comb begin
        mem_we_o = (phase == PH_PUSH);
        is_pop   = (phase == PH_POP);
        is_fill  = (phase == PH_FILL);
        mem_re_o = (phase == PH_VEC) || is_pop || is_fill;
    end
endmodule

// File: rtl/irq_ctx_seq_chk.sv
// Module: protocol checker for the interrupt context sequencer, bound to the
// top. Observes the memory port, stack pointer and handshake outputs.
module irq_ctx_seq_chk #(
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we_o,
    input logic              mem_re_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [ADDR_W-1:0] sp_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              is_pop,
    input logic              is_fill
);
    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we_o, mem_re_o}));                                       // R2
    AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> sp_o == ADDR_W'($past(mem_addr_o) - 1'b1));              // R3
    AST_POP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re_o && is_pop) |-> mem_addr_o == ADDR_W'(sp_o + 1'b1));         // R5
    AST_POP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re_o && is_pop) |=> sp_o == $past(mem_addr_o));                  // R5
    AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_fill && $past(is_fill)) |-> mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                                   // R7
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));                                // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_we_o && !mem_re_o));                                 // R8
endmodule

bind irq_ctx_seq irq_ctx_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_we_o   (mem_we_o),
    .mem_re_o   (mem_re_o),
    .mem_addr_o (mem_addr_o),
    .sp_o       (sp_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .is_pop     (is_pop),
    .is_fill    (is_fill)
);

// File: tb/irq_ctx_seq_bench.sv
module irq_ctx_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        take_i, rti_i;
    logic [15:0] vec_i, pc_i, sp_i;
    logic [7:0]  x_i, a_i, ccr_i;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_we, mem_re;
    logic [15:0] pc_o, sp_o;
    logic [7:0]  x_o, a_o, ccr_o;
    logic [23:0] pf_o;
    logic        busy_o, done_o;

    logic [7:0]  mem [256];
    logic        pre_we;
    logic [7:0]  pre_a, pre_d;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_ctx_seq u_irq_ctx_seq (
        .clk(clk), .rst_n(rst_n), .take_i(take_i), .vec_i(vec_i), .rti_i(rti_i),
        .pc_i(pc_i), .x_i(x_i), .a_i(a_i), .ccr_i(ccr_i), .sp_i(sp_i),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
        .mem_re_o(mem_re), .mem_rdata_i(mem_rdata), .pc_o(pc_o), .x_o(x_o),
        .a_o(a_o), .ccr_o(ccr_o), .sp_o(sp_o), .pf_o(pf_o), .busy_o(busy_o),
        .done_o(done_o)
    );

    // Byte memory model, indexed by the low address byte; test addresses avoid aliasing.
    always_comb mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) begin
        if (pre_we)      mem[pre_a] <= pre_d;
        else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end

    typedef struct packed {
        logic [15:0] sp;
        logic [15:0] pc;
        logic [7:0]  x;
        logic [7:0]  a;
        logic [7:0]  ccr;
        logic [15:0] vec;
        logic [15:0] vword;
    } row_t;

    localparam row_t ROWS [4] = '{
        '{16'h00F0, 16'h1240, 8'h11, 8'h22, 8'h60, 16'hFFF8, 16'h9A31},
        '{16'h0002, 16'h8050, 8'h33, 8'h44, 8'h6F, 16'hFFFA, 16'h4CE2},
        '{16'h0000, 16'hC060, 8'h55, 8'h66, 8'h01, 16'hFFF8, 16'h9A31},
        '{16'h0105, 16'hFFFF, 8'h77, 8'h88, 8'hF7, 16'hFFFA, 16'h4CE2}
    };

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(logic [7:0] a, logic [7:0] d);
        pre_we = 1'b1; pre_a = a; pre_d = d;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    // Runs until idle; returns the number of busy cycles. Optional disturbance mid-run.
    task automatic wait_idle(output int n, input bit disturb);
        n = 0;
        while (busy_o && n < 40) begin
            n++;
            if (disturb && n == 2) begin
                take_i = 1'b1; rti_i = 1'b1;
                pc_i = 16'hDEAD; x_i = 8'hEE; a_i = 8'hEE; ccr_i = 8'hEE;
                sp_i = 16'h0040; vec_i = 16'h0000;
            end else begin
                take_i = 1'b0; rti_i = 1'b0;
            end
            @(negedge clk);
        end
        take_i = 1'b0; rti_i = 1'b0;
    endtask

    task automatic do_take(row_t r, bit also_rti, bit disturb, output int n);
        take_i = 1'b1; rti_i = also_rti;
        sp_i = r.sp; pc_i = r.pc; x_i = r.x; a_i = r.a; ccr_i = r.ccr; vec_i = r.vec;
        @(negedge clk);
        take_i = 1'b0; rti_i = 1'b0;
        wait_idle(n, disturb);
    endtask

    task automatic do_rti(logic [15:0] sp, output int n);
        rti_i = 1'b1; sp_i = sp;
        pc_i = 16'h0000; x_i = 8'h00; a_i = 8'h00; ccr_i = 8'h00;
        @(negedge clk);
        rti_i = 1'b0;
        wait_idle(n, 1'b0);
    endtask

    task automatic check_entry(row_t r, int n);
        logic [15:0] s;
        s = r.sp;
        chk("R2 frame PC low", mem[s[7:0]], r.pc[7:0]);
        s = s - 16'd1; chk("R2 frame PC high", mem[s[7:0]], r.pc[15:8]);
        s = s - 16'd1; chk("R2 frame X", mem[s[7:0]], r.x);
        s = s - 16'd1; chk("R2 frame A", mem[s[7:0]], r.a);
        s = s - 16'd1; chk("R2 frame CCR", mem[s[7:0]], r.ccr);
        chk("R3 sp after take", sp_o, 16'(r.sp - 16'd5));
        chk("R4 ccr mask set", ccr_o, r.ccr | 8'h08);
        chk("R4 pc from vector", pc_o, r.vword);
        chk("R4 x kept", x_o, r.x);
        chk("R4 a kept", a_o, r.a);
        chk("R7 take busy cycles", n, 7);
        chk("R7 done pulse", done_o, 1'b1);
    endtask

    task automatic check_return(row_t r, int n);
        logic [15:0] p1, p2;
        p1 = r.pc + 16'd1; p2 = r.pc + 16'd2;
        chk("R5 ccr restored", ccr_o, r.ccr);
        chk("R5 a restored", a_o, r.a);
        chk("R5 x restored", x_o, r.x);
        chk("R5 pc restored", pc_o, r.pc);
        chk("R5 sp after return", sp_o, r.sp);
        chk("R6 prefetch bytes", pf_o, {mem[p2[7:0]], mem[p1[7:0]], mem[r.pc[7:0]]});
        chk("R7 return busy cycles", n, 8);
        chk("R7 done pulse", done_o, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog expired actual=hung expected=idle");
        finish_run();
    end

    initial begin
        int n;
        row_t r1, r2;
        rst_n = 1'b0; take_i = 1'b0; rti_i = 1'b0; pre_we = 1'b0; pre_a = '0; pre_d = '0;
        vec_i = '0; pc_i = '0; sp_i = '0; x_i = '0; a_i = '0; ccr_i = '0;
        repeat (3) @(negedge clk);
        // R1: reset state, held low
        chk("R1 busy in reset", busy_o, 0);
        chk("R1 done in reset", done_o, 0);
        chk("R1 strobes in reset", {mem_we, mem_re}, 0);
        chk("R1 sp in reset", sp_o, 0);
        chk("R1 pc in reset", pc_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", {busy_o, done_o, mem_we, mem_re}, 0);

        for (int i = 0; i < 256; i++) poke(8'(i), 8'(i * 7 + 3));
        poke(8'hF8, 8'h9A); poke(8'hF9, 8'h31);
        poke(8'hFA, 8'h4C); poke(8'hFB, 8'hE2);

        // Stimulus table: take then return for each row (row 1 wraps through zero).
        for (int i = 0; i < 4; i++) begin
            do_take(ROWS[i], 1'b0, 1'b0, n);
            check_entry(ROWS[i], n);
            @(negedge clk);
            chk("R7 done one cycle", done_o, 0);
            do_rti(sp_o, n);
            check_return(ROWS[i], n);
            @(negedge clk);
        end

        // R9: nested takes then two returns in LIFO order.
        r1 = '{16'h01A0, 16'h2344, 8'h9A, 8'hBC, 8'h40, 16'hFFF8, 16'h9A31};
        r2 = '{16'h019B, 16'h3456, 8'hA1, 8'hB2, 8'h44, 16'hFFFA, 16'h4CE2};
        do_take(r1, 1'b0, 1'b0, n);
        chk("R9 outer sp", sp_o, 16'h019B);
        do_take(r2, 1'b0, 1'b0, n);
        check_entry(r2, n);
        chk("R9 outer frame intact", mem[8'hA0], r1.pc[7:0]);
        do_rti(sp_o, n);
        check_return(r2, n);
        chk("R9 inner return sp", sp_o, 16'h019B);
        do_rti(sp_o, n);
        check_return(r1, n);
        @(negedge clk);

        // R8: strobes with conflicting inputs mid-sequence are ignored.
        do_take(ROWS[0], 1'b0, 1'b1, n);
        check_entry(ROWS[0], n);
        chk("R8 no restart after disturbance", busy_o, 0);
        @(negedge clk);
        chk("R8 stays idle", {busy_o, mem_we, mem_re}, 0);

        // R8: both strobes together while idle serve the take.
        do_take(ROWS[2], 1'b1, 1'b0, n);
        check_entry(ROWS[2], n);
        @(negedge clk);

        finish_run();
    end
endmodule